// File: doc/BRIEF.md
# Coalesced Status Write-Back Controller

This block keeps the status counters of one DMA direction and decides when their values must be pushed to host memory. It counts descriptor credits consumed, maintains the descriptor credit limit, counts completed descriptors and counts packets whose last beat has left on the outgoing stream. Every counter update arrives as a single-cycle event pulse from the surrounding data path.

A write-back can be requested at once by selected events, or deferred until enough coalesced events have built up or a tick-based timeout runs out. When a write-back is due, the block raises a request that carries a snapshot of all four counters and the 64-byte-aligned host address. The request is a valid/ready output. Once `wb_valid` is high it stays high, with data and address unchanged, until `wb_ready` is sampled high. A trigger that arrives while a request is stalled is remembered, and it produces exactly one further request after the stalled one is accepted. The bus transaction that moves the data is outside this block. Its error response comes back on `wb_err`.

Software reaches the configuration, timeout, address, error and counter registers over a simple word-addressed register bus. Writes take effect at the clock edge. Reads are combinational and have no side effects.

Top module: `stat_wb_ctrl`

## Requirements
- R1: After reset, every register reads 0 except the credit-limit counter (word 9), which reads RAM_DEPTH. `wb_valid` is low.
- R2: The configuration register (word 0) is laid out as follows.
  - Immediate enables: bit 0 completed descriptor, bit 1 packet, bit 2 credit consumed, bit 3 metadata pointer.
  - Coalesced enables: bit 4 credit consumed, bit 5 completed descriptor, bit 6 packet, bit 7 metadata pointer.
  - Bits 13:8 hold the event threshold minus one. Bits 31:14 read 0.
  - The timeout register (word 1) keeps tick count in bits 3:0 and timeout count in bits 7:4. Its other bits read 0.
- R3: The write-back address is the address high word (word 5) in bits 63:32 and the address low word (word 4) in bits 31:0. Address bits 5:0 always read and drive 0.
- R4: The consumed-credit counter (word 8) counts `ev_credit_used` pulses. The completed-descriptor counter (word 10) counts `ev_desc_done` pulses. The packet counter (word 11) increments only in a cycle where `tx_valid`, `tx_ready` and `tx_last` are all high.
- R5: Counter writes follow these rules.
  - Writing 0 to word 8, 10 or 11 clears that counter. Writing 0 to word 9 reloads RAM_DEPTH.
  - Writing a nonzero value to any counter word is ignored.
  - `ev_credit_add` increments the limit.
  - A write of 0 wins over an event in the same cycle.
- R6: An event whose immediate enable is set raises `wb_valid` at the next clock edge.
  - The snapshot includes that event.
  - `wb_data` packs consumed credits in bits 31:0, credit limit in 63:32, completed descriptors in 95:64 and packets in 127:96.
- R7: With coalescing enabled and threshold field N, a request is raised at the edge where the N+1-th coalesced event since the last write-back is counted.
- R8: With tick field T and timeout field C, a lone coalesced event with no other trigger raises `wb_valid` exactly (T+1)*(C+1) cycles after the edge that counted it.
- R9: The coalesced-event count and timeout are cleared by every write-back trigger, whether immediate, threshold or timeout.
- R10: An immediate trigger and a coalesce expiry in the same cycle produce a single request.
- R11: Back-pressure works as follows.
  - While `wb_valid` is high and `wb_ready` is low, `wb_valid`, `wb_data` and `wb_addr` hold.
  - Triggers during the stall yield exactly one further request once the stalled one is accepted.
  - That further request carries a fresh snapshot.
- R12: A `wb_err` pulse sets bit 0 of the error register (word 6).
  - Writing 1 to bit 0 clears it. Writing 0 leaves it set.
  - A set and a clear in the same cycle leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address (writes and reads) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| ev_credit_used | input | 1 | Descriptor credit consumed pulse |
| ev_credit_add | input | 1 | Credit limit increment pulse |
| ev_desc_done | input | 1 | Descriptor completed pulse |
| ev_md_ptr | input | 1 | Metadata pointer moved pulse |
| tx_valid | input | 1 | Observed outgoing stream valid |
| tx_ready | input | 1 | Observed outgoing stream ready |
| tx_last | input | 1 | Observed outgoing stream last beat |
| wb_valid | output | 1 | Write-back request valid |
| wb_ready | input | 1 | Write-back request accepted |
| wb_addr | output | 64 | Host address of the status block |
| wb_data | output | 128 | Counter snapshot |
| wb_err | input | 1 | Write-back error response pulse |

## Verification
The bench checks the exact cycle at which a timeout fires. A timer that starts one cycle late, or counts ticks off by one, moves the request by one or more cycles and is reported.

It checks that an immediate trigger clears partial coalescing. A design that keeps the old count after an unrelated write-back would fire early, and the scoreboard sees an unexpected request.

A simultaneous immediate trigger and threshold hit must give a single request. It also checks the stall case, where data must hold and exactly one later request with a fresh snapshot must follow. A design that drops or duplicates write-backs there leaves the scoreboard queue unbalanced.

The bench also covers stream beats that are not full end-of-packet transfers, a clear written in the same cycle as an event, and the limit reloading to the RAM depth instead of zero.

// File: rtl/stat_wb_pkg.sv
package stat_wb_pkg;
  localparam int REG_W  = 32;
  localparam int CNT_W  = 32;
  localparam int NUM_CNT = 4;
  localparam int NUM_EV = 4;

  // counter slots inside the counter bank
  localparam int C_USED = 0;
  localparam int C_LIM  = 1;
  localparam int C_DONE = 2;
  localparam int C_PKT  = 3;

  // event slots used for trigger selection
  localparam int EV_CREDIT = 0;
  localparam int EV_DESC   = 1;
  localparam int EV_PKT    = 2;
  localparam int EV_MD     = 3;

  typedef enum logic [3:0] {
    RA_CFG       = 4'd0,
    RA_TMO       = 4'd1,
    RA_ADDR_LO   = 4'd4,
    RA_ADDR_HI   = 4'd5,
    RA_ERR       = 4'd6,
    RA_CRED_USED = 4'd8,
    RA_CRED_LIM  = 4'd9,
    RA_DESC_DONE = 4'd10,
    RA_PKTS      = 4'd11
  } reg_addr_e;
endpackage

// File: rtl/wbc_cfg_regs.sv
module wbc_cfg_regs
  import stat_wb_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int THR_W  = 6,
  parameter int TICK_W = 4,
  parameter int TO_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [3:0]               wr_addr,
  input  logic [REG_W-1:0]         wr_data,
  input  logic                     err_set,
  output logic [8+THR_W-1:0]       cfg_q,
  output logic [TICK_W+TO_W-1:0]   tmo_q,
  output logic [NUM_EV-1:0]        imm_en,
  output logic [NUM_EV-1:0]        coal_en,
  output logic [THR_W-1:0]         thr,
  output logic [TICK_W-1:0]        tick,
  output logic [TO_W-1:0]          tmo_cnt,
  output logic [ADDR_W-1:0]        base_addr,
  output logic                     err_q
);
  localparam int CFG_W = 8 + THR_W;
  localparam int TMO_W = TICK_W + TO_W;
  localparam int HI_W  = ADDR_W - 32;

  logic [31:6]     lo_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      tmo_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr_en && wr_addr == RA_CFG)     cfg_q <= wr_data[CFG_W-1:0];
      if (wr_en && wr_addr == RA_TMO)     tmo_q <= wr_data[TMO_W-1:0];
      if (wr_en && wr_addr == RA_ADDR_LO) lo_q  <= wr_data[31:6];
      if (wr_en && wr_addr == RA_ADDR_HI) hi_q  <= wr_data[HI_W-1:0];
      if (err_set)
        err_q <= 1'b1;
      else if (wr_en && wr_addr == RA_ERR && wr_data[0])
        err_q <= 1'b0;
    end
  end

  // immediate enables: bit0 desc, bit1 pkt, bit2 credit, bit3 metadata
  assign imm_en[EV_DESC]   = cfg_q[0];
  assign imm_en[EV_PKT]    = cfg_q[1];
  assign imm_en[EV_CREDIT] = cfg_q[2];
  assign imm_en[EV_MD]     = cfg_q[3];
  // coalesced enables: bit4 credit, bit5 desc, bit6 pkt, bit7 metadata
  assign coal_en[EV_CREDIT] = cfg_q[4];
  assign coal_en[EV_DESC]   = cfg_q[5];
  assign coal_en[EV_PKT]    = cfg_q[6];
  assign coal_en[EV_MD]     = cfg_q[7];

  assign thr       = cfg_q[CFG_W-1:8];
  assign tick      = tmo_q[TICK_W-1:0];
  assign tmo_cnt   = tmo_q[TMO_W-1:TICK_W];
  assign base_addr = {hi_q, lo_q, 6'b0};
endmodule

// File: rtl/wbc_counters.sv
module wbc_counters
  import stat_wb_pkg::*;
#(
  parameter int RAM_DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_CNT-1:0] inc,
  input  logic [NUM_CNT-1:0] wr_sel,
  input  logic             wr_zero,
  output logic [CNT_W-1:0] cnt_q [NUM_CNT],
  output logic [CNT_W-1:0] cnt_d [NUM_CNT]
);
  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    localparam logic [CNT_W-1:0] CLR_VAL =
      (g == C_LIM) ? CNT_W'(RAM_DEPTH) : '0;

    always_comb begin
      if (wr_sel[g] && wr_zero)
        cnt_d[g] = CLR_VAL;
      else
        cnt_d[g] = cnt_q[g] + CNT_W'(inc[g]);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q[g] <= CLR_VAL;
      else        cnt_q[g] <= cnt_d[g];
    end
  end
endmodule

// File: rtl/wbc_coalesce.sv
module wbc_coalesce
  import stat_wb_pkg::*;
#(
  parameter int THR_W  = 6,
  parameter int TICK_W = 4,
  parameter int TO_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] hit,
  input  logic [THR_W-1:0]  thr,
  input  logic [TICK_W-1:0] tick,
  input  logic [TO_W-1:0]   tmo_cnt,
  input  logic              flush,
  output logic              fire,
  output logic [THR_W-1:0]  cnt_q
);
  localparam int HIT_W = $clog2(NUM_EV + 1);

  logic [HIT_W-1:0]  hits;
  logic [THR_W:0]    sum;
  logic [TICK_W-1:0] pre_q;
  logic [TO_W-1:0]   tk_q;
  logic              pending, expire, over;

  assign hits    = HIT_W'($countones(hit));
  assign sum     = {1'b0, cnt_q} + (THR_W+1)'(hits);
  assign over    = (hits != '0) && (sum > {1'b0, thr});
  assign pending = (cnt_q != '0);
  assign expire  = pending && (pre_q == tick) && (tk_q == tmo_cnt);
  assign fire    = over || expire;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      cnt_q <= '0;
      pre_q <= '0;
      tk_q  <= '0;
    end else begin
      cnt_q <= sum[THR_W-1:0];
      if (!pending) begin
        pre_q <= '0;
        tk_q  <= '0;
      end else if (pre_q == tick) begin
        pre_q <= '0;
        tk_q  <= tk_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wbc_req.sv
module wbc_req #(
  parameter int DW = 128,
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic [DW-1:0] snap,
  input  logic [AW-1:0] addr_in,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic [AW-1:0] addr
);
  logic defer_q;
  logic load;

  assign load = trig || defer_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      defer_q <= 1'b0;
      data    <= '0;
      addr    <= '0;
    end else if (!valid || ready) begin
      valid   <= load;
      defer_q <= 1'b0;
      if (load) begin
        data <= snap;
        addr <= addr_in;
      end
    end else if (trig) begin
      defer_q <= 1'b1;
    end
  end
endmodule

// File: rtl/stat_wb_ctrl.sv
module stat_wb_ctrl
  import stat_wb_pkg::*;
#(
  parameter int RAM_DEPTH = 64,
  parameter int ADDR_W    = 64,
  parameter int THR_W     = 6,
  parameter int TICK_W    = 4,
  parameter int TO_W      = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr_en,
  input  logic [3:0]               reg_addr,
  input  logic [REG_W-1:0]         reg_wdata,
  output logic [REG_W-1:0]         reg_rdata,
  input  logic                     ev_credit_used,
  input  logic                     ev_credit_add,
  input  logic                     ev_desc_done,
  input  logic                     ev_md_ptr,
  input  logic                     tx_valid,
  input  logic                     tx_ready,
  input  logic                     tx_last,
  output logic                     wb_valid,
  input  logic                     wb_ready,
  output logic [ADDR_W-1:0]        wb_addr,
  output logic [NUM_CNT*CNT_W-1:0] wb_data,
  input  logic                     wb_err
);
  localparam int DW = NUM_CNT * CNT_W;

  logic [8+THR_W-1:0]     cfg_q;
  logic [TICK_W+TO_W-1:0] tmo_q;
  logic [NUM_EV-1:0]      imm_en, coal_en, ev;
  logic [THR_W-1:0]       thr, coal_cnt;
  logic [TICK_W-1:0]      tick;
  logic [TO_W-1:0]        tmo_cnt;
  logic [ADDR_W-1:0]      base_addr;
  logic                   err_q, eop_xfer, coal_fire, imm_fire, trig;
  logic [NUM_CNT-1:0]     inc, wr_sel;
  logic [CNT_W-1:0]       cnt_q [NUM_CNT];
  logic [CNT_W-1:0]       cnt_d [NUM_CNT];
  logic [DW-1:0]          snap;
  logic [CNT_W-1:0]       pkt_cnt;

  assign eop_xfer = tx_valid && tx_ready && tx_last;

  assign ev[EV_CREDIT] = ev_credit_used;
  assign ev[EV_DESC]   = ev_desc_done;
  assign ev[EV_PKT]    = eop_xfer;
  assign ev[EV_MD]     = ev_md_ptr;

  assign inc[C_USED] = ev_credit_used;
  assign inc[C_LIM]  = ev_credit_add;
  assign inc[C_DONE] = ev_desc_done;
  assign inc[C_PKT]  = eop_xfer;

  assign wr_sel[C_USED] = reg_wr_en && reg_addr == RA_CRED_USED;
  assign wr_sel[C_LIM]  = reg_wr_en && reg_addr == RA_CRED_LIM;
  assign wr_sel[C_DONE] = reg_wr_en && reg_addr == RA_DESC_DONE;
  assign wr_sel[C_PKT]  = reg_wr_en && reg_addr == RA_PKTS;

  wbc_cfg_regs #(
    .ADDR_W(ADDR_W), .THR_W(THR_W), .TICK_W(TICK_W), .TO_W(TO_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .err_set(wb_err), .cfg_q(cfg_q), .tmo_q(tmo_q),
    .imm_en(imm_en), .coal_en(coal_en), .thr(thr), .tick(tick),
    .tmo_cnt(tmo_cnt), .base_addr(base_addr), .err_q(err_q)
  );

  wbc_counters #(.RAM_DEPTH(RAM_DEPTH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(inc), .wr_sel(wr_sel),
    .wr_zero(reg_wdata == '0), .cnt_q(cnt_q), .cnt_d(cnt_d)
  );

  assign imm_fire = |(ev & imm_en);
  assign trig     = imm_fire || coal_fire;

  wbc_coalesce #(.THR_W(THR_W), .TICK_W(TICK_W), .TO_W(TO_W)) u_coal (
    .clk(clk), .rst_n(rst_n), .hit(ev & coal_en), .thr(thr), .tick(tick),
    .tmo_cnt(tmo_cnt), .flush(trig), .fire(coal_fire), .cnt_q(coal_cnt)
  );

  assign snap    = {cnt_d[C_PKT], cnt_d[C_DONE], cnt_d[C_LIM], cnt_d[C_USED]};
  assign pkt_cnt = cnt_q[C_PKT];

  wbc_req #(.DW(DW), .AW(ADDR_W)) u_req (
    .clk(clk), .rst_n(rst_n), .trig(trig), .snap(snap), .addr_in(base_addr),
    .ready(wb_ready), .valid(wb_valid), .data(wb_data), .addr(wb_addr)
  );

  always_comb begin
    case (reg_addr)
      RA_CFG:       reg_rdata = REG_W'(cfg_q);
      RA_TMO:       reg_rdata = REG_W'(tmo_q);
      RA_ADDR_LO:   reg_rdata = base_addr[31:0];
      RA_ADDR_HI:   reg_rdata = base_addr[ADDR_W-1:32];
      RA_ERR:       reg_rdata = REG_W'(err_q);
      RA_CRED_USED: reg_rdata = cnt_q[C_USED];
      RA_CRED_LIM:  reg_rdata = cnt_q[C_LIM];
      RA_DESC_DONE: reg_rdata = cnt_q[C_DONE];
      RA_PKTS:      reg_rdata = cnt_q[C_PKT];
      default:      reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/stat_wb_ctrl_chk.sv
module stat_wb_ctrl_chk #(
  parameter int AW    = 64,
  parameter int DW    = 128,
  parameter int THR_W = 6,
  parameter int CW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wb_valid,
  input logic             wb_ready,
  input logic [AW-1:0]    wb_addr,
  input logic [DW-1:0]    wb_data,
  input logic             trig,
  input logic             err_q,
  input logic             wb_err,
  input logic [THR_W-1:0] coal_cnt,
  input logic [CW-1:0]    pkt_cnt,
  input logic             eop_xfer
);
  // R11
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_data) && $stable(wb_addr));

  // R3
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_addr[5:0] == 6'd0);

  // R6
  no_spurious_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> $past(trig));

  // R9
  coal_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> coal_cnt == '0);

  // R12
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(wb_err));

  // R4
  pkt_only_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_cnt != $past(pkt_cnt)) && (pkt_cnt != '0) |-> $past(eop_xfer));
endmodule

bind stat_wb_ctrl stat_wb_ctrl_chk #(
  .AW(ADDR_W), .DW(NUM_CNT*CNT_W), .THR_W(THR_W), .CW(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_ready(wb_ready),
  .wb_addr(wb_addr), .wb_data(wb_data), .trig(trig), .err_q(err_q),
  .wb_err(wb_err), .coal_cnt(coal_cnt), .pkt_cnt(pkt_cnt),
  .eop_xfer(eop_xfer)
);

// File: tb/test_stat_wb_ctrl.sv
module test_stat_wb_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr_en = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         ev_credit_used = 0, ev_credit_add = 0, ev_desc_done = 0, ev_md_ptr = 0;
  logic         tx_valid = 0, tx_ready = 0, tx_last = 0;
  logic         wb_valid;
  logic         wb_ready = 1'b1;
  logic [63:0]  wb_addr;
  logic [127:0] wb_data;
  logic         wb_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stat_wb_ctrl #(.RAM_DEPTH(DEPTH)) i_stat_wb_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_credit_used(ev_credit_used), .ev_credit_add(ev_credit_add),
    .ev_desc_done(ev_desc_done), .ev_md_ptr(ev_md_ptr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
    .wb_data(wb_data), .wb_err(wb_err)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [127:0] d;
    logic [63:0]  a;
    string        tag;
  } item_t;
  item_t exp_q[$];

  logic [31:0] m_used = 0, m_lim = DEPTH, m_done = 0, m_pkts = 0;
  logic [63:0] m_addr = 0;

  task automatic check(input string r, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic push_exp(input string tag);
    item_t it;
    it.d = {m_pkts, m_done, m_lim, m_used};
    it.a = m_addr;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  // scoreboard monitor: samples away from the rising edge
  always @(negedge clk) begin
    #2;
    if (rst_n && wb_valid && wb_ready) begin
      if (exp_q.size() == 0) begin
        check("R6 unexpected write-back", wb_data, 128'hx);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check({it.tag, " data"}, wb_data, it.d);
        check({it.tag, " addr"}, {64'd0, wb_addr}, {64'd0, it.a});
      end
    end
  end

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_check(input string r, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(r, {96'd0, reg_rdata}, {96'd0, exp});
  endtask

  // one-cycle event; model updated from the requirement rules
  task automatic ev(input bit used, input bit add, input bit desc, input bit md,
                    input bit tv, input bit tr, input bit tl);
    @(negedge clk);
    ev_credit_used = used; ev_credit_add = add; ev_desc_done = desc; ev_md_ptr = md;
    tx_valid = tv; tx_ready = tr; tx_last = tl;
    @(negedge clk);
    ev_credit_used = 0; ev_credit_add = 0; ev_desc_done = 0; ev_md_ptr = 0;
    tx_valid = 0; tx_ready = 0; tx_last = 0;
    if (used) m_used++;
    if (add)  m_lim++;
    if (desc) m_done++;
    if (tv && tr && tl) m_pkts++;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    reg_check("R1 cfg", 4'd0, 32'd0);
    reg_check("R1 limit", 4'd9, DEPTH);
    reg_check("R1 used", 4'd8, 32'd0);
    reg_check("R1 pkts", 4'd11, 32'd0);
    check("R1 wb_valid", {127'd0, wb_valid}, 128'd0);

    // R2 field layout and reserved bits
    reg_write(4'd0, 32'hFFFF_FFFF);
    reg_check("R2 cfg reserved", 4'd0, 32'h0000_3FFF);
    reg_write(4'd1, 32'hFFFF_FFFF);
    reg_check("R2 timeout reserved", 4'd1, 32'h0000_00FF);
    reg_write(4'd0, 32'd0);
    reg_write(4'd1, 32'hFF);

    // R3 address alignment
    reg_write(4'd4, 32'h1234_5678);
    reg_write(4'd5, 32'h0000_ABCD);
    m_addr = 64'h0000_ABCD_1234_5640;
    reg_check("R3 addr lo aligned", 4'd4, 32'h1234_5640);
    reg_check("R3 addr hi", 4'd5, 32'h0000_ABCD);

    // R6 immediate on completed descriptor (bit 0)
    reg_write(4'd0, 32'h1);
    ev(0, 0, 1, 0, 0, 0, 0);
    push_exp("R6 immediate desc");
    #1 check("R6 valid next edge", {127'd0, wb_valid}, 128'd1);
    idle(2);

    // R4 packet counting only on full last-beat transfer, immediate pkt (bit 1)
    reg_write(4'd0, 32'h2);
    ev(0, 0, 0, 0, 1, 0, 1);
    ev(0, 0, 0, 0, 1, 1, 0);
    ev(0, 0, 0, 0, 0, 1, 1);
    reg_check("R4 no count without transfer", 4'd11, 32'd0);
    ev(0, 0, 0, 0, 1, 1, 1);
    push_exp("R4 eop write-back");
    idle(2);
    reg_check("R4 pkt count", 4'd11, 32'd1);
    ev(1, 0, 0, 0, 0, 0, 0);
    reg_check("R4 used count", 4'd8, 32'd1);

    // R7 threshold: coalesced credit (bit 4), field 2 -> 3 events
    reg_write(4'd0, 32'h210);
    ev(1, 0, 0, 0, 0, 0, 0);
    idle(2);
    ev(1, 0, 0, 0, 0, 0, 0);
    idle(3);
    check("R7 no early write-back", {127'd0, wb_valid}, 128'd0);
    ev(1, 0, 0, 0, 0, 0, 0);
    push_exp("R7 threshold reached");
    idle(3);

    // R9 count cleared by immediate write-back (imm desc bit 0 + coal credit)
    reg_write(4'd0, 32'h211);
    ev(1, 0, 0, 0, 0, 0, 0);
    ev(1, 0, 0, 0, 0, 0, 0);
    ev(0, 0, 1, 0, 0, 0, 0);
    push_exp("R9 immediate flush");
    idle(2);
    ev(1, 0, 0, 0, 0, 0, 0);
    ev(1, 0, 0, 0, 0, 0, 0);
    idle(3);
    check("R9 stale count not used", {127'd0, wb_valid}, 128'd0);
    ev(1, 0, 0, 0, 0, 0, 0);
    push_exp("R9 fresh threshold");
    idle(3);

    // R8 timeout: coal desc (bit 5), field 10, tick 1, count 2 -> 6 cycles
    reg_write(4'd0, 32'hA20);
    reg_write(4'd1, 32'h21);
    ev(0, 0, 1, 0, 0, 0, 0);
    idle(5);
    #1 check("R8 not before timeout", {127'd0, wb_valid}, 128'd0);
    push_exp("R8 timeout");
    @(negedge clk);
    #1 check("R8 at timeout", {127'd0, wb_valid}, 128'd1);
    idle(3);

    // R10 immediate credit (bit 2) + coalesced desc (bit 5), threshold field 0
    reg_write(4'd0, 32'h24);
    ev(1, 0, 1, 0, 0, 0, 0);
    push_exp("R10 single request");
    idle(3);
    check("R10 no second request", {127'd0, wb_valid}, 128'd0);

    // R11 back-pressure
    reg_write(4'd0, 32'h1);
    @(negedge clk); wb_ready = 1'b0;
    ev(0, 0, 1, 0, 0, 0, 0);
    push_exp("R11 stalled request");
    begin
      logic [127:0] held;
      #1 held = wb_data;
      ev(0, 0, 1, 0, 0, 0, 0);
      push_exp("R11 follow-up fresh snapshot");
      idle(2);
      #1 check("R11 valid held", {127'd0, wb_valid}, 128'd1);
      check("R11 data held", wb_data, held);
    end
    @(negedge clk); wb_ready = 1'b1;
    idle(4);
    check("R11 exactly one follow-up", {127'd0, wb_valid}, 128'd0);

    // R5 clearing rules
    reg_write(4'd0, 32'd0);
    reg_write(4'd8, 32'd0);
    m_used = 0;
    reg_check("R5 used cleared", 4'd8, 32'd0);
    reg_write(4'd10, 32'd5);
    reg_check("R5 nonzero write ignored", 4'd10, m_done);
    ev(0, 1, 0, 0, 0, 0, 0);
    ev(0, 1, 0, 0, 0, 0, 0);
    reg_check("R5 limit increments", 4'd9, DEPTH + 2);
    reg_write(4'd9, 32'd0);
    m_lim = DEPTH;
    reg_check("R5 limit reloads depth", 4'd9, DEPTH);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 4'd10; reg_wdata = 32'd0; ev_desc_done = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; ev_desc_done = 1'b0;
    m_done = 0;
    reg_check("R5 clear beats event", 4'd10, 32'd0);

    // R12 sticky error
    @(negedge clk); wb_err = 1'b1;
    @(negedge clk); wb_err = 1'b0;
    reg_check("R12 error set", 4'd6, 32'd1);
    reg_write(4'd6, 32'd0);
    reg_check("R12 write 0 keeps", 4'd6, 32'd1);
    reg_write(4'd6, 32'd1);
    reg_check("R12 write 1 clears", 4'd6, 32'd0);
    @(negedge clk);
    wb_err = 1'b1; reg_wr_en = 1'b1; reg_addr = 4'd6; reg_wdata = 32'd1;
    @(negedge clk);
    wb_err = 1'b0; reg_wr_en = 1'b0; reg_wdata = 32'd0;
    reg_check("R12 set wins", 4'd6, 32'd1);

    idle(5);
    check("R6 all expected write-backs seen", 128'(exp_q.size()), 128'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule